// File: doc/BRIEF.md
# DMA Channel Register File and Interrupt Front End

This block is the software-facing register front end of a multi-channel DMA controller. It takes single-cycle 32-bit register reads and writes on a word-addressed bus and sorts them into a small global group and a per-channel group. The global group has a controller control word, two interrupt mask words and two interrupt source words. Each channel has eight words: a control/status word (CSR), a transfer size, source and destination addresses, one address mask for each of them, a descriptor pointer and a software pointer.

The channel engines sit outside this block. Each engine receives a one-cycle start pulse and a one-cycle cancel pulse. It reports busy, chunk-complete, done and error back to the block. Done and error events update the channel CSR flags. When a channel has the matching interrupt enabled and its mask bit set, the event also loads the first interrupt source word with that channel's one-hot code. The single interrupt output is high while any source bit is set whose mask bit is also set.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, except the source-mask and destination-mask words of every channel, which read 0xFFFFFFFC. The irq output and all start and cancel pulses are low.
- R2: Word addresses 0 to 4 select the control word, mask A, mask B, source A and source B. Channel c, register r sits at address 8 + 8c + r, with r = 0 CSR, 1 size, 2 source address, 3 source mask, 4 destination address, 5 destination mask, 6 descriptor pointer and 7 software pointer. Every word except the CSR and the control word reads back the last value written to it.
- R3: Global addresses 5 to 7 and channel slots at or beyond NUM_CH read zero. Writes to them change nothing.
- R4: The global control word always reads zero. Writing it, including setting its pause bit (bit 0), starts nothing and changes no register.
- R5: CSR bits are: 0 enable, 1 busy (shows the engine's busy input, read-only), 2 done, 3 error, 4 done-interrupt enable, 5 error-interrupt enable, 6 chunk-complete, 7 done-interrupt flag, 8 error-interrupt flag, 9 to 15 writable options. A CSR write changes only the bits in mask 0x0000FE31.
- R6: A CSR write with bit 0 set, to a channel whose stored enable is 0, raises that channel's start pulse for exactly the one cycle after the write. A CSR write with bit 0 clear raises its cancel pulse for one cycle. A write with bit 0 set to a channel that is already enabled raises neither pulse.
- R7: A CSR read returns the current value. In the same access it clears bits 2, 3, 6, 7 and 8, so a second read shows them as zero.
- R8: A done event clears enable, sets done and clears error. An error event clears enable and sets error. A chunk event sets chunk-complete. An event in the same cycle as a clearing CSR read leaves its flag set.
- R9: A done (or error) event sets the done-interrupt (or error-interrupt) flag and overwrites source A with the channel's one-hot code only when CSR bit 4 (or bit 5) and the channel's bit in mask A are both set. Otherwise source A is unchanged.
- R10: When several qualified events occur in one cycle, source A takes the one-hot code of the lowest-numbered channel. A qualified event overrides a software write to source A in the same cycle.
- R11: irq is the OR of the bits of source A that are also set in mask A. It follows a write of either word in the next cycle, and software clears it by writing source A.
- R12: Mask B and source B are plain storage and have no effect on irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears CSR flags) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| eng_start | output | NUM_CH | One-cycle start pulse per channel |
| eng_cancel | output | NUM_CH | One-cycle cancel pulse per channel |
| eng_busy | input | NUM_CH | Engine busy level per channel |
| eng_chunk | input | NUM_CH | Chunk-complete event per channel |
| eng_done | input | NUM_CH | Transfer-done event per channel |
| eng_err | input | NUM_CH | Error or stop event per channel |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench writes a distinct pattern to every one of the 256 addresses and reads them all back. A decoder that got the stride, the slot bound or the global range wrong would show data in the wrong slot, or data in an unmapped hole. The write-mask test writes all ones to a CSR, which catches any status bit that software can overwrite. The bench also checks that start fires only on a 0-to-1 change of enable, so a design that pulses on every enabled write would be caught. Races are driven in the same cycle: two channels reporting done together, an event against a software write of source A, and a chunk event against a clearing read. A wrong priority, a read-clear that wipes a new event, or a software write that hides an interrupt each gives a wrong source or CSR value.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

    localparam int unsigned REG_W = 32;

    // number of mapped global words (control, mask A, mask B, source A, source B)
    localparam int unsigned GLOB_CNT = 5;

    localparam logic [2:0] G_CTRL  = 3'd0;
    localparam logic [2:0] G_MASKA = 3'd1;
    localparam logic [2:0] G_MASKB = 3'd2;
    localparam logic [2:0] G_SRCA  = 3'd3;
    localparam logic [2:0] G_SRCB  = 3'd4;

    typedef enum logic [2:0] {
        CR_CSR     = 3'd0,
        CR_SIZE    = 3'd1,
        CR_SRC_ADR = 3'd2,
        CR_SRC_MSK = 3'd3,
        CR_DST_ADR = 3'd4,
        CR_DST_MSK = 3'd5,
        CR_DESC    = 3'd6,
        CR_SWPTR   = 3'd7
    } ch_reg_e;

    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_BUSY     = 1;
    localparam int unsigned B_DONE     = 2;
    localparam int unsigned B_ERR      = 3;
    localparam int unsigned B_DONE_IE  = 4;
    localparam int unsigned B_ERR_IE   = 5;
    localparam int unsigned B_CHUNK    = 6;
    localparam int unsigned B_DONE_INT = 7;
    localparam int unsigned B_ERR_INT  = 8;

    localparam logic [REG_W-1:0] CSR_WMASK = 32'h0000_FE31;
    localparam logic [REG_W-1:0] CSR_RCLR  = 32'h0000_01CC;
    localparam logic [REG_W-1:0] MASK_RST  = 32'hFFFF_FFFC;

endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
    import dma_rb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned CH_BASE = 8,
    parameter int unsigned IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glob_hit,
    output logic [2:0]        glob_sel,
    output logic              ch_hit,
    output logic [IDX_W-1:0]  ch_idx,
    output ch_reg_e           ch_reg
);

    localparam int unsigned STRIDE_LG = 3;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        off      = addr - ADDR_W'(CH_BASE);
        slot     = off >> STRIDE_LG;
        glob_hit = addr < ADDR_W'(GLOB_CNT);
        glob_sel = addr[2:0];
        ch_hit   = (addr >= ADDR_W'(CH_BASE)) && (slot < ADDR_W'(NUM_CH));
        ch_idx   = slot[IDX_W-1:0];
        ch_reg   = ch_reg_e'(off[STRIDE_LG-1:0]);
    end

endmodule

// File: rtl/dma_rb_csr_next.sv
module dma_rb_csr_next
    import dma_rb_pkg::*;
(
    input  logic [REG_W-1:0] csr_q,
    input  logic             wr_csr,
    input  logic             rd_csr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ev_done,
    input  logic             ev_err,
    input  logic             ev_chunk,
    input  logic             mask_bit,
    output logic [REG_W-1:0] csr_d,
    output logic             start,
    output logic             cancel,
    output logic             done_fire,
    output logic             err_fire
);

    always_comb begin
        csr_d     = csr_q;
        start     = wr_csr && wdata[B_EN] && !csr_q[B_EN];
        cancel    = wr_csr && !wdata[B_EN];
        done_fire = ev_done && csr_q[B_DONE_IE] && mask_bit;
        err_fire  = ev_err && csr_q[B_ERR_IE] && mask_bit;

        if (wr_csr) begin
            csr_d = (csr_q & ~CSR_WMASK) | (wdata & CSR_WMASK);
        end
        if (rd_csr) begin
            csr_d = csr_d & ~CSR_RCLR;
        end
        if (ev_chunk) begin
            csr_d[B_CHUNK] = 1'b1;
        end
        if (ev_done) begin
            csr_d[B_EN]   = 1'b0;
            csr_d[B_DONE] = 1'b1;
            csr_d[B_ERR]  = 1'b0;
            if (done_fire) begin
                csr_d[B_DONE_INT] = 1'b1;
            end
        end
        if (ev_err) begin
            csr_d[B_EN]  = 1'b0;
            csr_d[B_ERR] = 1'b1;
            if (err_fire) begin
                csr_d[B_ERR_INT] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq
    import dma_rb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] fire,
    input  logic [REG_W-1:0]  src_q,
    input  logic [REG_W-1:0]  mask_q,
    output logic              hit,
    output logic [REG_W-1:0]  onehot,
    output logic              irq
);

    logic [NUM_CH-1:0] lowest;

    always_comb begin
        lowest = fire & (~fire + 1'b1);
        hit    = |fire;
        onehot = REG_W'(lowest);
        irq    = |(src_q & mask_q);
    end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_rb_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CH_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] eng_start,
    output logic [NUM_CH-1:0] eng_cancel,
    input  logic [NUM_CH-1:0] eng_busy,
    input  logic [NUM_CH-1:0] eng_chunk,
    input  logic [NUM_CH-1:0] eng_done,
    input  logic [NUM_CH-1:0] eng_err,
    output logic              irq
);

    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0][REG_W-1:0] csr;
        logic [NUM_CH-1:0][REG_W-1:0] size;
        logic [NUM_CH-1:0][REG_W-1:0] sadr;
        logic [NUM_CH-1:0][REG_W-1:0] smsk;
        logic [NUM_CH-1:0][REG_W-1:0] dadr;
        logic [NUM_CH-1:0][REG_W-1:0] dmsk;
        logic [NUM_CH-1:0][REG_W-1:0] desc;
        logic [NUM_CH-1:0][REG_W-1:0] swp;
        logic [REG_W-1:0]             mask_a;
        logic [REG_W-1:0]             mask_b;
        logic [REG_W-1:0]             src_a;
        logic [REG_W-1:0]             src_b;
        logic [NUM_CH-1:0]            start;
        logic [NUM_CH-1:0]            cancel;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic              glob_hit;
    logic [2:0]        glob_sel;
    logic              ch_hit;
    logic [IDX_W-1:0]  ch_idx;
    ch_reg_e           ch_reg;

    logic [NUM_CH-1:0][REG_W-1:0] csr_nx;
    logic [NUM_CH-1:0]            st_pulse;
    logic [NUM_CH-1:0]            cn_pulse;
    logic [NUM_CH-1:0]            done_fire;
    logic [NUM_CH-1:0]            err_fire;
    logic                         irq_hit;
    logic [REG_W-1:0]             irq_onehot;
    logic [REG_W-1:0]             csr_view;

    dma_rb_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CH  (NUM_CH),
        .CH_BASE (CH_BASE),
        .IDX_W   (IDX_W)
    ) u_dec (
        .addr     (bus_addr),
        .glob_hit (glob_hit),
        .glob_sel (glob_sel),
        .ch_hit   (ch_hit),
        .ch_idx   (ch_idx),
        .ch_reg   (ch_reg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel_csr;
        assign sel_csr = ch_hit && (ch_reg == CR_CSR) && (ch_idx == IDX_W'(g));

        dma_rb_csr_next u_csr (
            .csr_q     (st_q.csr[g]),
            .wr_csr    (bus_wr && sel_csr),
            .rd_csr    (bus_rd && sel_csr),
            .wdata     (bus_wdata),
            .ev_done   (eng_done[g]),
            .ev_err    (eng_err[g]),
            .ev_chunk  (eng_chunk[g]),
            .mask_bit  (st_q.mask_a[g]),
            .csr_d     (csr_nx[g]),
            .start     (st_pulse[g]),
            .cancel    (cn_pulse[g]),
            .done_fire (done_fire[g]),
            .err_fire  (err_fire[g])
        );
    end

    dma_rb_irq #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .fire   (done_fire | err_fire),
        .src_q  (st_q.src_a),
        .mask_q (st_q.mask_a),
        .hit    (irq_hit),
        .onehot (irq_onehot),
        .irq    (irq)
    );

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.csr    = csr_nx;
        st_d.start  = st_pulse;
        st_d.cancel = cn_pulse;

        if (bus_wr && glob_hit) begin
            case (glob_sel)
                G_MASKA: st_d.mask_a = bus_wdata;
                G_MASKB: st_d.mask_b = bus_wdata;
                G_SRCA:  st_d.src_a  = bus_wdata;
                G_SRCB:  st_d.src_b  = bus_wdata;
                default: ;
            endcase
        end

        if (bus_wr && ch_hit) begin
            case (ch_reg)
                CR_SIZE:    st_d.size[ch_idx] = bus_wdata;
                CR_SRC_ADR: st_d.sadr[ch_idx] = bus_wdata;
                CR_SRC_MSK: st_d.smsk[ch_idx] = bus_wdata;
                CR_DST_ADR: st_d.dadr[ch_idx] = bus_wdata;
                CR_DST_MSK: st_d.dmsk[ch_idx] = bus_wdata;
                CR_DESC:    st_d.desc[ch_idx] = bus_wdata;
                CR_SWPTR:   st_d.swp[ch_idx]  = bus_wdata;
                default:    ;
            endcase
        end

        // hardware event has the last word on the source register
        if (irq_hit) begin
            st_d.src_a = irq_onehot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.smsk <= {NUM_CH{MASK_RST}};
            st_q.dmsk <= {NUM_CH{MASK_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    // read data path
    always_comb begin
        csr_view         = st_q.csr[ch_idx];
        csr_view[B_BUSY] = eng_busy[ch_idx];
        bus_rdata        = '0;
        if (bus_rd) begin
            if (glob_hit) begin
                case (glob_sel)
                    G_MASKA: bus_rdata = st_q.mask_a;
                    G_MASKB: bus_rdata = st_q.mask_b;
                    G_SRCA:  bus_rdata = st_q.src_a;
                    G_SRCB:  bus_rdata = st_q.src_b;
                    default: bus_rdata = '0;
                endcase
            end else if (ch_hit) begin
                case (ch_reg)
                    CR_CSR:     bus_rdata = csr_view;
                    CR_SIZE:    bus_rdata = st_q.size[ch_idx];
                    CR_SRC_ADR: bus_rdata = st_q.sadr[ch_idx];
                    CR_SRC_MSK: bus_rdata = st_q.smsk[ch_idx];
                    CR_DST_ADR: bus_rdata = st_q.dadr[ch_idx];
                    CR_DST_MSK: bus_rdata = st_q.dmsk[ch_idx];
                    CR_DESC:    bus_rdata = st_q.desc[ch_idx];
                    CR_SWPTR:   bus_rdata = st_q.swp[ch_idx];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    assign eng_start  = st_q.start;
    assign eng_cancel = st_q.cancel;

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [NUM_CH-1:0] eng_start,
    input logic [NUM_CH-1:0] eng_cancel,
    input logic [NUM_CH-1:0] eng_done,
    input logic [NUM_CH-1:0] eng_err,
    input logic [31:0]       src_a,
    input logic              irq
);

    // R6: one write gives a start or a cancel, never both
    assert_start_cancel_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start & eng_cancel) == '0);

    // R6: a start pulse lasts a single cycle
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start & $past(eng_start)) == '0);

    // R9: source A moves only on a write or an engine event
    assert_src_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(|eng_done) && !(|eng_err)) |=> $stable(src_a));

    // R11: irq rises only after a write or an engine event
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_wr || (|eng_done) || (|eng_err)));

endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .eng_start  (eng_start),
    .eng_cancel (eng_cancel),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .src_a      (st_q.src_a),
    .irq        (irq)
);

// File: tb/sim_dma_regbank.sv
`timescale 1ns/1ps
module sim_dma_regbank;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] eng_start, eng_cancel;
    logic [NCH-1:0] eng_busy = '0, eng_chunk = '0, eng_done = '0, eng_err = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_regbank #(.NUM_CH(NCH), .ADDR_W(8), .CH_BASE(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_busy(eng_busy),
        .eng_chunk(eng_chunk), .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic ev(input logic [NCH-1:0] dn, input logic [NCH-1:0] er, input logic [NCH-1:0] ck);
        @(negedge clk);
        eng_done = dn; eng_err = er; eng_chunk = ck;
        @(posedge clk);
        #1 eng_done = '0; eng_err = '0; eng_chunk = '0;
    endtask

    function automatic logic [31:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b, ~b, b ^ 8'h5A, b + 8'd3};
    endfunction

    function automatic logic [31:0] reset_exp(input int a);
        if (a >= 8 && a < 8 + 8 * NCH && (((a - 8) % 8) == 3 || ((a - 8) % 8) == 5))
            return 32'hFFFF_FFFC;
        return 32'h0;
    endfunction

    function automatic logic [31:0] sweep_exp(input int a);
        if (a >= 1 && a <= 4) return pat(a);
        if (a >= 8 && a < 8 + 8 * NCH)
            return (((a - 8) % 8) == 0) ? (pat(a) & 32'h0000_FE31) : pat(a);
        return 32'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1: reset values everywhere
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 start", 32'(eng_start), 32'h0);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            chk("R1 reset value", v, reset_exp(a));
        end

        // R2/R3: write every address, read every address
        for (int a = 0; a < 256; a++) wr(8'(a), pat(a));
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            chk("R2 R3 sweep", v, sweep_exp(a));
        end

        do_reset();
        // R4: pause bit in control word does nothing
        wr(8'd0, 32'h1);
        @(negedge clk);
        chk("R4 no start", 32'(eng_start), 32'h0);
        chk("R4 irq", {31'b0, irq}, 32'h0);
        rd(8'd0, v); chk("R4 ctrl reads zero", v, 32'h0);

        // R3: hole and missing channel
        wr(8'd5, 32'h1234_5678); rd(8'd5, v); chk("R3 hole", v, 32'h0);
        wr(8'd40, 32'hFFFF_FFFF);
        @(negedge clk); chk("R3 no start", 32'(eng_start), 32'h0);
        rd(8'd40, v); chk("R3 missing channel", v, 32'h0);

        // R5/R6: write mask and start
        wr(8'd8, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R6 start", 32'(eng_start), 32'h1);
        chk("R6 no cancel", 32'(eng_cancel), 32'h0);
        @(negedge clk);
        chk("R6 start one cycle", 32'(eng_start), 32'h0);
        rd(8'd8, v); chk("R5 write mask", v, 32'h0000_FE31);
        wr(8'd8, 32'h0000_0001);
        @(negedge clk); chk("R6 no restart", 32'(eng_start), 32'h0);
        wr(8'd8, 32'h0);
        @(negedge clk); chk("R6 cancel", 32'(eng_cancel), 32'h1);
        eng_busy = 4'b0001;
        rd(8'd8, v); chk("R5 busy bit", v, 32'h2);
        eng_busy = '0;
        wr(8'd32, 32'h1);
        @(negedge clk); chk("R6 start ch3", 32'(eng_start), 32'h8);

        // R8/R9/R11: qualified done on channel 0
        wr(8'd1, 32'h5);
        wr(8'd8, 32'h11);
        ev(4'b0001, 4'b0, 4'b0);
        @(negedge clk); chk("R11 irq set", {31'b0, irq}, 32'h1);
        rd(8'd3, v); chk("R9 source one-hot", v, 32'h1);
        rd(8'd8, v); chk("R8 R9 done flags", v, 32'h94);
        rd(8'd8, v); chk("R7 flags cleared", v, 32'h10);

        // R9: mask bit off on channel 1
        wr(8'd16, 32'h11);
        ev(4'b0010, 4'b0, 4'b0);
        rd(8'd16, v); chk("R9 unqualified csr", v, 32'h14);
        rd(8'd3, v); chk("R9 source kept", v, 32'h1);

        // R11: software clear
        wr(8'd3, 32'h0);
        @(negedge clk); chk("R11 irq cleared", {31'b0, irq}, 32'h0);

        // R8/R9: error on channel 2
        wr(8'd24, 32'h21);
        ev(4'b0, 4'b0100, 4'b0);
        rd(8'd24, v); chk("R8 R9 error flags", v, 32'h128);
        rd(8'd3, v); chk("R9 error source", v, 32'h4);

        // R10: lowest channel wins
        wr(8'd24, 32'h10);
        ev(4'b0101, 4'b0, 4'b0);
        rd(8'd3, v); chk("R10 priority", v, 32'h1);

        // R10: event beats software write
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'd3; bus_wdata = 32'h0; eng_done = 4'b0100;
        @(posedge clk);
        #1 bus_wr = 1'b0; eng_done = '0;
        rd(8'd3, v); chk("R10 event over write", v, 32'h4);

        // R8: chunk event during clearing read
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'd8; eng_chunk = 4'b0001;
        #1 v = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0; eng_chunk = '0;
        chk("R7 read value", v, 32'h94);
        rd(8'd8, v); chk("R8 event survives clear", v, 32'h50);

        // R12: second pair does not drive irq
        wr(8'd3, 32'h0);
        wr(8'd2, 32'hFFFF_FFFF);
        wr(8'd4, 32'hFFFF_FFFF);
        @(negedge clk); chk("R12 irq stays low", {31'b0, irq}, 32'h0);
        rd(8'd4, v); chk("R12 storage", v, 32'hFFFF_FFFF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule